// File: doc/BRIEF.md
# Busy-Vetoed Live Trigger Gate

This block merges a set of asynchronous trigger-source lines into a single raw trigger pulse. It issues a matching live trigger only when the readout chain is ready: the run-enable level must be high, none of the external busy lines may be asserted, and an internal busy latch must be clear. Each live trigger sets that latch. The latch stays set until a clear-busy strobe or a module-clear strobe arrives, so one event is accepted per readout cycle.

For dead-time measurement the block generates a periodic pulser in two forms. The raw pulser runs freely. The live pulser is the same pulse, gated by the same veto as the live trigger. The ratio of the two counts gives the live fraction without the double-counting that the raw trigger can suffer. The same divider chain also produces slow ticks nominally at 10 Hz and 1 Hz. With the default parameters and a 40 MHz clock, the pulser runs at 10 kHz.

Top module: `trig_gate`

## Requirements
- R1: Each source input is synchronised by two flip-flops and edge-detected. A rising edge on `src_i[i]` with `SRC_EN[i]` = 1 and `go_i` high produces `raw_trig_o` high for exactly one cycle, on the third rising clock edge after the source changes. A source whose `SRC_EN` bit is 0 produces no trigger.
- R2: A source held high for many cycles yields exactly one raw trigger. Rising edges on several enabled sources in the same cycle also yield exactly one raw trigger.
- R3: `live_trig_o` pulses together with `raw_trig_o` when no veto applies. It stays low when any bit of `busy_i` has been high for at least two cycles before the source edge reaches the detector.
- R4: A live trigger sets an internal busy latch that suppresses later live triggers, while raw triggers continue. A one-cycle `clr_busy_i` or `mod_clr_i` strobe clears the latch. If a new live trigger and a clear fall in the same cycle, the latch ends up set.
- R5: While `go_i` is low, neither `raw_trig_o` nor `live_trig_o` is issued, and `live_pls_o` is suppressed. `raw_pls_o` keeps running.
- R6: `raw_pls_o` is a one-cycle pulse repeating every `PULSE_DIV` clock cycles.
- R7: `live_pls_o` is high only in a cycle where `raw_pls_o` is high. It is high in that cycle exactly when no veto applies, where veto means `go_i` low, any synchronised busy bit high, or the busy latch set.
- R8: `tick10_o` is a one-cycle pulse every `PULSE_DIV*TEN_DIV` cycles and coincides with a `raw_pls_o` pulse. `tick1_o` is a one-cycle pulse every `PULSE_DIV*TEN_DIV*ONE_DIV` cycles and coincides with a `tick10_o` pulse.
- R9: `mod_clr_i` restarts the divider chain. The first `raw_pls_o` after the strobe comes exactly `PULSE_DIV` cycles after the clock edge that samples the strobe.
- R10: While `rst_n` is low, all outputs are low and the busy latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Run enable; low vetoes all trigger outputs |
| src_i | input | N_SRC | Asynchronous trigger-source lines |
| busy_i | input | N_BUSY | Asynchronous busy lines from readout partners |
| clr_busy_i | input | 1 | One-cycle strobe that clears the busy latch |
| mod_clr_i | input | 1 | One-cycle strobe that clears the busy latch and restarts the dividers |
| raw_trig_o | output | 1 | One-cycle raw trigger |
| live_trig_o | output | 1 | One-cycle trigger accepted past the veto |
| raw_pls_o | output | 1 | Free-running pulser |
| live_pls_o | output | 1 | Pulser gated by the veto |
| tick10_o | output | 1 | Slow tick, nominally 10 Hz |
| tick1_o | output | 1 | Slow tick, nominally 1 Hz |

## Verification
The hardest state to reach from the ports is the busy latch. It cannot be observed directly and has no control of its own; it reveals itself only when a later source edge produces a raw trigger without a live one, or when the live pulser drops out while the raw pulser keeps running. The stimulus therefore issues a first accepted trigger, sends a second source edge and then waits through two pulser periods with the busy lines quiet. It then clears the latch by each of the two strobes in turn and confirms that live triggers and live pulses return. The slow ticks are reached by shrinking the divider parameters, so that several full tick periods fit into a short run.

// File: rtl/trig_gate.sv
module trig_gate #(
  parameter int N_SRC = 4,
  parameter int N_BUSY = 7,
  parameter logic [N_SRC-1:0] SRC_EN = '1,
  parameter int PULSE_DIV = 4000,
  parameter int TEN_DIV = 1000,
  parameter int ONE_DIV = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_BUSY-1:0] busy_i,
  input  logic              clr_busy_i,
  input  logic              mod_clr_i,
  output logic              raw_trig_o,
  output logic              live_trig_o,
  output logic              raw_pls_o,
  output logic              live_pls_o,
  output logic              tick10_o,
  output logic              tick1_o
);
  localparam int PW = $clog2(PULSE_DIV + 1);
  localparam int TW = $clog2(TEN_DIV + 1);
  localparam int OW = $clog2(ONE_DIV + 1);

  logic [N_SRC-1:0]  s1, s2, s3;
  logic [N_BUSY-1:0] b1, b2;
  logic              busy_q;
  logic [PW-1:0]     pcnt;
  logic [TW-1:0]     tcnt;
  logic [OW-1:0]     ocnt;

  wire [N_SRC-1:0] rise = s2 & ~s3 & SRC_EN;
  wire fire      = go_i & (|rise);
  wire veto      = ~go_i | busy_q | (|b2);
  wire live_next = fire & ~veto;
  wire pls_hit   = (pcnt == PW'(PULSE_DIV - 1));
  wire ten_hit   = pls_hit & (tcnt == TW'(TEN_DIV - 1));
  wire one_hit   = ten_hit & (ocnt == OW'(ONE_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      b1 <= '0; b2 <= '0;
    end else begin
      s1 <= src_i; s2 <= s1; s3 <= s2;
      b1 <= busy_i; b2 <= b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= live_next | (busy_q & ~(clr_busy_i | mod_clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; tcnt <= '0; ocnt <= '0;
    end else if (mod_clr_i) begin
      pcnt <= '0; tcnt <= '0; ocnt <= '0;
    end else begin
      pcnt <= pls_hit ? '0 : pcnt + 1'b1;
      if (pls_hit) tcnt <= ten_hit ? '0 : tcnt + 1'b1;
      if (ten_hit) ocnt <= one_hit ? '0 : ocnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_trig_o <= 1'b0; live_trig_o <= 1'b0;
      raw_pls_o  <= 1'b0; live_pls_o  <= 1'b0;
      tick10_o   <= 1'b0; tick1_o     <= 1'b0;
    end else begin
      raw_trig_o  <= fire;
      live_trig_o <= live_next;
      raw_pls_o   <= pls_hit & ~mod_clr_i;
      live_pls_o  <= pls_hit & ~mod_clr_i & ~veto;
      tick10_o    <= ten_hit & ~mod_clr_i;
      tick1_o     <= one_hit & ~mod_clr_i;
    end
  end
endmodule

// File: rtl/trig_gate_chk.sv
module trig_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic go_i,
  input logic raw_trig_o,
  input logic live_trig_o,
  input logic raw_pls_o,
  input logic live_pls_o,
  input logic tick10_o,
  input logic tick1_o,
  input logic busy_q
);
  // R3
  live_implies_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_trig_o |-> raw_trig_o);
  // R4
  latch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_trig_o |=> busy_q);
  // R4
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_trig_o |=> !live_trig_o);
  // R5
  go_gates_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_trig_o |-> $past(go_i));
  // R7
  live_pls_in_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_pls_o |-> raw_pls_o);
  // R6
  pls_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_pls_o |=> !raw_pls_o);
  // R8
  tick10_on_pls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick10_o |-> raw_pls_o);
  // R8
  tick1_on_tick10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick1_o |-> tick10_o);
endmodule

bind trig_gate trig_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go_i(go_i),
  .raw_trig_o(raw_trig_o), .live_trig_o(live_trig_o),
  .raw_pls_o(raw_pls_o), .live_pls_o(live_pls_o),
  .tick10_o(tick10_o), .tick1_o(tick1_o), .busy_q(busy_q)
);

// File: tb/trig_gate_test.sv
module trig_gate_test;
  localparam int PD = 8, TD = 3, OD = 2;
  logic clk = 0, rst_n = 0, go_i = 0, clr_busy_i = 0, mod_clr_i = 0;
  logic [3:0] src_i = '0;
  logic [6:0] busy_i = '0;
  logic raw_trig_o, live_trig_o, raw_pls_o, live_pls_o, tick10_o, tick1_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  trig_gate #(.N_SRC(4), .N_BUSY(7), .SRC_EN(4'b1011), .PULSE_DIV(PD),
              .TEN_DIV(TD), .ONE_DIV(OD)) uut (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .src_i(src_i), .busy_i(busy_i),
    .clr_busy_i(clr_busy_i), .mod_clr_i(mod_clr_i),
    .raw_trig_o(raw_trig_o), .live_trig_o(live_trig_o),
    .raw_pls_o(raw_pls_o), .live_pls_o(live_pls_o),
    .tick10_o(tick10_o), .tick1_o(tick1_o));

  // {go, busy[6:0], src[3:0], raw count, live count}
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 7'b0000000, 4'b0001, 1'b1, 1'b1},
    {1'b1, 7'b0000000, 4'b0100, 1'b0, 1'b0},
    {1'b0, 7'b0000000, 4'b0001, 1'b0, 1'b0},
    {1'b1, 7'b0000001, 4'b0010, 1'b1, 1'b0},
    {1'b1, 7'b1000000, 4'b1000, 1'b1, 1'b0},
    {1'b1, 7'b0000000, 4'b1011, 1'b1, 1'b1},
    {1'b1, 7'b0010000, 4'b0001, 1'b1, 1'b0},
    {1'b1, 7'b0000000, 4'b1000, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic strobe_clr(input bit modc);
    @(negedge clk);
    if (modc) mod_clr_i = 1; else clr_busy_i = 1;
    @(negedge clk);
    mod_clr_i = 0; clr_busy_i = 0;
  endtask

  task automatic src_pulse(input logic [3:0] s, output int nr, output int nl);
    nr = 0; nl = 0;
    @(negedge clk);
    src_i = s;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 2) src_i = '0;
      nr += int'(raw_trig_o); nl += int'(live_trig_o);
    end
  endtask

  task automatic wait_pls();
    do @(negedge clk); while (!raw_pls_o);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    int nr, nl, n;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({raw_trig_o, live_trig_o, raw_pls_o, live_pls_o, tick10_o, tick1_o} == 6'b0,
          "R10 outputs in reset",
          {raw_trig_o, live_trig_o, raw_pls_o, live_pls_o, tick10_o, tick1_o}, 0);
    rst_n = 1;

    // R1 R3 R5 vector walk
    foreach (VEC[k]) begin
      strobe_clr(0);
      go_i = VEC[k][13]; busy_i = VEC[k][12:6];
      repeat (3) @(negedge clk);
      src_pulse(VEC[k][5:2], nr, nl);
      check(nr == int'(VEC[k][1]), $sformatf("R1 raw count vec%0d", k), nr, VEC[k][1]);
      check(nl == int'(VEC[k][0]), $sformatf("R3 live count vec%0d", k), nl, VEC[k][0]);
      busy_i = '0;
    end

    // R1 latency
    go_i = 1; strobe_clr(0); repeat (3) @(negedge clk);
    src_i = 4'b0001; n = 0;
    do begin @(negedge clk); n++; end while (!raw_trig_o && n < 10);
    check(n == 3, "R1 latency", n, 3);
    @(negedge clk);
    check(raw_trig_o == 0, "R1 one cycle wide", raw_trig_o, 0);
    // R2 held source
    n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); n += int'(raw_trig_o); end
    check(n == 0, "R2 held source single trigger", n, 0);
    src_i = '0; repeat (4) @(negedge clk);

    // R4 busy latch
    strobe_clr(0); repeat (3) @(negedge clk);
    src_pulse(4'b0001, nr, nl);
    check(nl == 1, "R4 first live", nl, 1);
    src_pulse(4'b0001, nr, nl);
    check(nr == 1 && nl == 0, "R4 latched veto", nl, 0);
    // R7 live pulser suppressed by latch
    wait_pls(); check(live_pls_o == 0, "R7 pulser vetoed by latch", live_pls_o, 0);
    wait_pls(); check(live_pls_o == 0, "R7 pulser vetoed by latch 2", live_pls_o, 0);
    strobe_clr(0);
    src_pulse(4'b0010, nr, nl);
    check(nl == 1, "R4 live after clear-busy", nl, 1);
    strobe_clr(1);
    src_pulse(4'b1000, nr, nl);
    check(nl == 1, "R4 live after module clear", nl, 1);

    // R7 live pulser follows raw pulser
    strobe_clr(0);
    wait_pls(); check(live_pls_o == 1, "R7 live pulse when ready", live_pls_o, 1);
    busy_i = 7'b0001000; repeat (3) @(negedge clk);
    wait_pls(); check(live_pls_o == 0, "R7 live pulse vetoed by busy", live_pls_o, 0);
    busy_i = '0; go_i = 0; repeat (3) @(negedge clk);
    wait_pls(); check(live_pls_o == 0, "R5 live pulse vetoed by go", live_pls_o, 0);
    go_i = 1;

    // R6 period
    wait_pls(); n = 0;
    do begin @(negedge clk); n++; end while (!raw_pls_o);
    check(n == PD, "R6 pulser period", n, PD);

    // R9 module clear restart
    repeat (3) @(negedge clk);
    strobe_clr(1); n = 0;
    do begin @(negedge clk); n++; end while (!raw_pls_o);
    check(n == PD, "R9 restart delay", n, PD);

    // R8 ticks
    do @(negedge clk); while (!tick10_o);
    check(raw_pls_o == 1, "R8 tick10 on pulse", raw_pls_o, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick10_o);
    check(n == PD * TD, "R8 tick10 period", n, PD * TD);
    do @(negedge clk); while (!tick1_o);
    check(tick10_o == 1, "R8 tick1 on tick10", tick10_o, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick1_o);
    check(n == PD * TD * OD, "R8 tick1 period", n, PD * TD * OD);

    summary();
  end
endmodule